// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator

This block decides when a UART transmit path reports that its holding stage is empty, and when that event raises the transmit interrupt. It watches the occupancy of a 16-entry transmit FIFO, the holding-register write strobe, the interrupt-identification read strobe, the FIFO enable bit and its change pulse, the interrupt enable bits, a baud-rate tick and the programmed frame length. It drives the empty status bit, the interrupt request and a four-bit identification code.

In FIFO mode the empty report can be held back. If the FIFO never held two or more bytes at once since the status last rose, the report waits for one frame time minus one stop bit, counted in baud ticks. If a burst of two or more bytes was seen, the report is immediate. In non-FIFO mode the report is always immediate. When every interrupt enable bit is clear, the block is in polled mode: status still updates but no request is raised.

The block carries no data, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. The FIFO storage and the serial shifter sit outside the block.

Top module: `tx_empty_irq_gen`

## Requirements
- R1: After reset, `thre` is 1, `irq` is 0 and `int_id` is 4'h1.
- R2: A non-zero `fifo_level` with no `fifo_en_toggle` clears `thre` on the next edge, and a `thr_wr` pulse clears the pending interrupt.
- R3: In FIFO mode, when `fifo_level` returns to 0 without having reached 2 since `thre` last rose, `thre` and the pending interrupt rise on the (`frame_bits` - 1)th `baud_tick` counted after the first empty cycle, and not before.
- R4: In FIFO mode, when `fifo_level` reached 2 or more since `thre` last rose, `thre` rises on the edge that ends the first cycle with `fifo_level` equal to 0. That rise clears the burst record.
- R5: A non-zero `fifo_level` during the delay abandons it, and the next empty cycle restarts the full count.
- R6: An `iir_rd` pulse clears the pending interrupt and leaves `thre` unchanged.
- R7: A `fifo_en_toggle` pulse sets `thre` and the pending interrupt on the next edge and discards any delay or burst record.
- R8: `irq` is the pending interrupt gated by `ier[1]`. `int_id` is 4'h2 while `irq` is 1 and 4'h1 otherwise.
- R9: With `ier` equal to 0 (polled mode), `irq` stays 0 while `thre` keeps updating. A pending interrupt is kept and appears once `ier[1]` is set.
- R10: With `fifo_en` at 0, `thre` rises on the edge after the first cycle with `fifo_level` at 0, with no delay.
- R11: When the rise of `thre` and an `iir_rd` or `thr_wr` fall in the same cycle, the rise wins and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enable level |
| fifo_en_toggle | input | 1 | One-cycle pulse when the FIFO enable bit changes |
| ier | input | 4 | Interrupt enable bits; bit 1 enables the transmit interrupt |
| fifo_level | input | LVL_W (5) | Bytes currently in the transmit FIFO (0 to DEPTH) |
| thr_wr | input | 1 | Holding-register write strobe |
| iir_rd | input | 1 | Interrupt-identification read strobe |
| baud_tick | input | 1 | One pulse per bit time |
| frame_bits | input | FB_W (4) | Bit times per frame, stop bits included |
| thre | output | 1 | Transmit holding stage empty status |
| irq | output | 1 | Transmit interrupt request |
| int_id | output | 4 | 4'h2 while requesting, 4'h1 otherwise |

## Verification
Two events can land in the same cycle: the rise of the empty status, which arms the interrupt, and a host strobe (identification read or holding write), which clears it. The bench drives an identification read in the very cycle that the FIFO level first reads zero in non-FIFO mode, where the rise is immediate. The outcome is judged at the ports: the request must still be high after that edge, and it must fall only after a second read. A second overlap is also exercised: a FIFO-enable change arriving while the empty status is already high must still re-arm the request.

// File: rtl/txe_pkg.sv
package txe_pkg;
  typedef enum logic [3:0] {
    ID_NONE = 4'h1,
    ID_THRE = 4'h2
  } txe_id_e;

  localparam int BURST_MIN = 2;
endpackage

// File: rtl/txe_burst_track.sv
module txe_burst_track #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             clr,
  output logic             burst_seen
);
  import txe_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      burst_seen <= 1'b0;
    else if (clr)
      burst_seen <= 1'b0;
    else if (fifo_level >= LVL_W'(BURST_MIN))
      burst_seen <= 1'b1;
  end
endmodule

// File: rtl/txe_char_delay.sv
module txe_char_delay #(
  parameter int FB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            baud_tick,
  input  logic [FB_W-1:0] frame_bits,
  output logic            busy,
  output logic            done
);
  logic [FB_W-1:0] remain;

  // fires on the tick that consumes the last remaining bit time
  assign done = busy && baud_tick && !abort && (remain <= FB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (abort) begin
      busy   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= frame_bits - FB_W'(1);   // final stop bit excluded
    end else if (done) begin
      busy   <= 1'b0;
    end else if (busy && baud_tick) begin
      remain <= remain - FB_W'(1);
    end
  end
endmodule

// File: rtl/txe_irq_pend.sv
module txe_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic enable,
  output logic irq
);
  logic pend;

  // an arming event outranks a clearing strobe in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (set_evt)
      pend <= 1'b1;
    else if (clr_evt)
      pend <= 1'b0;
  end

  assign irq = pend && enable;
endmodule

// File: rtl/tx_empty_irq_gen.sv
module tx_empty_irq_gen #(
  parameter int DEPTH = 16,
  parameter int FB_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             fifo_en_toggle,
  input  logic [3:0]       ier,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             baud_tick,
  input  logic [FB_W-1:0]  frame_bits,
  output logic             thre,
  output logic             irq,
  output logic [3:0]       int_id
);
  import txe_pkg::*;

  logic empty;
  logic burst_seen;
  logic dly_busy, dly_done;
  logic dly_start, dly_abort;
  logic fast_path;
  logic thre_set, thre_clr, thre_rise;
  logic burst_clr;

  assign empty     = (fifo_level == '0);
  assign fast_path = !fifo_en || burst_seen;

  assign dly_start = fifo_en && empty && !thre && !burst_seen
                     && !dly_busy && !fifo_en_toggle;
  assign dly_abort = dly_busy && (!empty || fifo_en_toggle || !fifo_en);

  assign thre_set  = fifo_en_toggle
                     || (empty && !thre && (fast_path || dly_done));
  assign thre_clr  = !empty && !fifo_en_toggle;
  assign thre_rise = thre_set && !thre;
  assign burst_clr = thre_rise || fifo_en_toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      thre <= 1'b1;
    else if (thre_set)
      thre <= 1'b1;
    else if (thre_clr)
      thre <= 1'b0;
  end

  txe_burst_track #(.LVL_W(LVL_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .clr        (burst_clr),
    .burst_seen (burst_seen)
  );

  txe_char_delay #(.FB_W(FB_W)) u_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (dly_start),
    .abort      (dly_abort),
    .baud_tick  (baud_tick),
    .frame_bits (frame_bits),
    .busy       (dly_busy),
    .done       (dly_done)
  );

  txe_irq_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (thre_rise || fifo_en_toggle),
    .clr_evt (thr_wr || iir_rd),
    .enable  (ier[1]),
    .irq     (irq)
  );

  assign int_id = irq ? ID_THRE : ID_NONE;
endmodule

// File: rtl/txe_irq_chk.sv
module txe_irq_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             fifo_en_toggle,
  input logic [3:0]       ier,
  input logic [LVL_W-1:0] fifo_level,
  input logic             iir_rd,
  input logic             thre,
  input logic             irq,
  input logic [3:0]       int_id
);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ier[1]);

  a_r8_id_while_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_id == 4'h2));

  a_r9_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |-> !irq);

  a_r2_level_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0 && !fifo_en_toggle) |=> !thre);

  a_r7_toggle_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en_toggle |=> thre);

  a_r10_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fifo_level == '0) |=> thre);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && thre && !fifo_en_toggle) |=> !irq);
endmodule

bind tx_empty_irq_gen txe_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fifo_en        (fifo_en),
  .fifo_en_toggle (fifo_en_toggle),
  .ier            (ier),
  .fifo_level     (fifo_level),
  .iir_rd         (iir_rd),
  .thre           (thre),
  .irq            (irq),
  .int_id         (int_id)
);

// File: tb/tx_empty_irq_gen_bench.sv
module tx_empty_irq_gen_bench;
  localparam int LVL_W = 5;
  localparam int FB_W  = 4;
  localparam int NV    = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, fifo_en_toggle = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
  logic baud_tick = 1'b0;
  logic [3:0] ier = 4'h2;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [FB_W-1:0] frame_bits = 4'd4;
  logic thre, irq;
  logic [3:0] int_id;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tx_empty_irq_gen u_tx_empty_irq_gen (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_en_toggle(fifo_en_toggle),
    .ier(ier), .fifo_level(fifo_level), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .baud_tick(baud_tick), .frame_bits(frame_bits),
    .thre(thre), .irq(irq), .int_id(int_id)
  );

  // {en, toggle, ier[3:0], level[4:0], wr, rd, tick, exp_thre, exp_irq}; frame_bits = 4
  localparam logic [15:0] VEC [NV] = '{
    {1'b1,1'b1,4'h2,5'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // 0  R7 toggle arms
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b1,1'b0,1'b1,1'b0}, // 1  R6 read clears
    {1'b1,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 2  R2 single write
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // 3  R3 delay starts
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 4  R3 tick 1
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // 5
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 6  R3 tick 2
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b1,1'b1}, // 7  R3 tick 3 fires
    {1'b1,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 8  R2
    {1'b1,1'b0,4'h2,5'd2,1'b1,1'b0,1'b0,1'b0,1'b0}, // 9  R4 burst
    {1'b1,1'b0,4'h2,5'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // 10
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // 11 R4 immediate
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b1,1'b0,1'b1,1'b0}, // 12 R6
    {1'b1,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 13 R4 record was cleared
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // 14 delay starts
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 15 tick 1
    {1'b1,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 16 R5 refill aborts
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // 17 R5 restart
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 18
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 19 R5 not early
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b1,1'b1,1'b1}, // 20 R5 full count
    {1'b1,1'b0,4'h0,5'd0,1'b0,1'b0,1'b0,1'b1,1'b0}, // 21 R9 polled
    {1'b1,1'b0,4'h0,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 22 R9
    {1'b1,1'b0,4'h0,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // 23
    {1'b1,1'b0,4'h0,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 24
    {1'b1,1'b0,4'h0,5'd0,1'b0,1'b0,1'b1,1'b0,1'b0}, // 25
    {1'b1,1'b0,4'h0,5'd0,1'b0,1'b0,1'b1,1'b1,1'b0}, // 26 R9 status updates
    {1'b1,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // 27 R8 enable shows pend
    {1'b0,1'b1,4'h2,5'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // 28 R7 toggle when set
    {1'b0,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 29
    {1'b0,1'b0,4'h2,5'd0,1'b0,1'b0,1'b0,1'b1,1'b1}, // 30 R10 immediate
    {1'b0,1'b0,4'h2,5'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // 31
    {1'b0,1'b0,4'h2,5'd0,1'b0,1'b1,1'b0,1'b1,1'b1}, // 32 R11 rise beats read
    {1'b0,1'b0,4'h2,5'd0,1'b0,1'b1,1'b0,1'b1,1'b0}  // 33 R11 second read
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    fifo_en_toggle = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0; baud_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 thre", int'(thre), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 int_id", int'(int_id), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      fifo_en = v[15]; fifo_en_toggle = v[14]; ier = v[13:10];
      fifo_level = v[9:5]; thr_wr = v[4]; iir_rd = v[3]; baud_tick = v[2];
      @(negedge clk);
      chk($sformatf("R3/R4 vec%0d thre", i), int'(thre), int'(v[1]));
      chk($sformatf("R8 vec%0d irq", i), int'(irq), int'(v[0]));
      chk($sformatf("R8 vec%0d int_id", i), int'(int_id), v[0] ? 2 : 1);
    end
    idle_in();

    // R3 with a longer frame: 11 bit times -> 10 ticks
    fifo_en = 1'b1; ier = 4'h2; frame_bits = 4'd11;
    fifo_level = 5'd1; thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0; fifo_level = 5'd0;
    @(negedge clk);
    for (int k = 1; k <= 10; k++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      if (k == 9) chk("R3 tick9 thre", int'(thre), 0);
      if (k == 10) begin
        chk("R3 tick10 thre", int'(thre), 1);
        chk("R3 tick10 irq", int'(irq), 1);
      end
      @(negedge clk);
    end

    // R1 reset during a delay
    fifo_level = 5'd1; thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0; fifo_level = 5'd0;
    @(negedge clk);
    chk("R3 pending delay thre", int'(thre), 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset thre", int'(thre), 1);
    chk("R1 mid reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule